// File: doc/BRIEF.md
# Threshold-Paced Transmit Sample Buffer

This block is a sample store that sits between a DMA engine and a serial audio shifter. The DMA side pushes 32-bit entries. The shifter side pops one entry for each serial word it sends. The block decides when to raise a DMA request, so that transfers can be grouped into bursts.

Each instance is built for one direction. In the transmit build, the request follows the number of free entries. In the receive build, the request follows the number of stored entries. A programmable threshold holds the burst size minus one. In element mode the request asks for a single entry at a time.

In the transmit build, the first request after enabling (or after a clear) stays raised until the store is completely full. This avoids a start-up underrun. The block also flags reads from an empty store and writes to a full one.

Top module: `audio_thr_fifo`

## Requirements
- R1: After reset the level is 0, both error flags are 0 and, with the enable low, the request is low.
- R2: Entries leave on the pop side in the order they were pushed, 32 bits wide. `pop_data` shows the oldest entry combinationally, and a pop removes it at the clock edge.
- R3: The store holds exactly DEPTH (default 1024) entries. A push while full is dropped, leaves the level at DEPTH, and sets the sticky `overflow` flag.
- R4: A pop while empty presents zero on `pop_data`, leaves the level at 0, and sets the sticky `underrun` flag.
- R5: A threshold value N written through `thr_we`/`thr_wdata` means N+1 samples. A value above MAX_THR (default 767) is stored as MAX_THR.
- R6: Transmit build: once enabled, the request stays high from an empty store until the level reaches DEPTH, whatever the threshold.
- R7: Transmit build, threshold mode (`thr_mode`=1), after that fill: the request is high exactly when the number of free entries is at least threshold+1.
- R8: Element mode (`thr_mode`=0): the transmit request is high when at least one entry is free (after the initial fill). The receive request is high when at least one entry is stored.
- R9: Receive build, threshold mode: the request is high exactly when the level is at least threshold+1. There is no fill phase.
- R10: A threshold write is used by the request decision from the cycle after the write edge.
- R11: A `clr` pulse empties the store, clears both flags, and re-arms the transmit fill phase. The stored threshold is kept.
- R12: With `enable` low the request is low. Pushes and pops still act on the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush of data and flags |
| enable | input | 1 | Allows the DMA request |
| thr_mode | input | 1 | 1 = threshold mode, 0 = element mode |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | 10 | Threshold value (samples minus one) |
| push | input | 1 | DMA-side write |
| push_data | input | 32 | DMA-side write data |
| pop | input | 1 | Shifter-side read |
| pop_data | output | 32 | Oldest entry, zero when empty |
| dma_req | output | 1 | DMA request |
| level | output | 11 | Number of stored entries |
| underrun | output | 1 | Sticky empty-read flag |
| overflow | output | 1 | Sticky full-write flag |

## Verification
A corrupt level counter shows at once on `level`. Within one cycle it also misplaces the edge of `dma_req`, because the free-space comparison reads the same counter. Pointer faults do not touch the level, so the bench compares each popped value with a model queue; a skipped or repeated slot shows on the next read of that slot. A fill-phase flag that fails to re-arm or to drop shows as a request that is high when free space is below the threshold, or low before the store is full. Probing just below and just above each threshold crossing catches such faults in the cycle they occur.

// File: rtl/audio_thr_fifo.sv
`timescale 1ns/1ps
module audio_thr_fifo #(
  parameter int DEPTH   = 1024,
  parameter int WIDTH   = 32,
  parameter bit RX_MODE = 1'b0,
  parameter int MAX_THR = 767,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic             thr_mode,
  input  logic             thr_we,
  input  logic [AW-1:0]    thr_wdata,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             dma_req,
  output logic [LW-1:0]    level,
  output logic             underrun,
  output logic             overflow
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, thr_q;
  logic [LW-1:0]    cnt;
  logic             filling;

  wire full    = (cnt == LW'(DEPTH));
  wire empty   = (cnt == '0);
  wire push_ok = push & ~full;
  wire pop_ok  = pop & ~empty;
  wire [LW-1:0] free_n = LW'(DEPTH) - cnt;
  wire [LW-1:0] need   = thr_mode ? (LW'(thr_q) + LW'(1)) : LW'(1);
  wire [AW-1:0] thr_in = (thr_wdata > AW'(MAX_THR)) ? AW'(MAX_THR) : thr_wdata;

  assign level    = cnt;
  assign pop_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
      if (pop && empty) underrun <= 1'b1;
      if (push && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_we) thr_q <= thr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                filling <= 1'b1;
    else if (clr || !enable)   filling <= 1'b1;
    else if (full)             filling <= 1'b0;
  end

  generate
    if (RX_MODE) begin : g_rx
      assign dma_req = enable & (cnt >= need);
    end else begin : g_tx
      assign dma_req = enable & ((filling & ~full) | (free_n >= need));

      // R6
      fill_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (level != LW'(DEPTH)));
    end
  endgenerate

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (level == $past(level)));

  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  // R4
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (underrun && level == '0));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0 && !underrun && !overflow));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

endmodule

// File: tb/audio_thr_fifo_test.sv
`timescale 1ns/1ps
module audio_thr_fifo_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] q[$];

  logic clr = 0, en = 0, mode = 1, twe = 0, psh = 0, pp = 0;
  logic [9:0] twd = '0;
  logic [31:0] pd = '0, pdat;
  logic req, unr, ovf;
  logic [10:0] lvl;

  audio_thr_fifo uut (.clk(clk), .rst_n(rst_n), .clr(clr), .enable(en), .thr_mode(mode),
    .thr_we(twe), .thr_wdata(twd), .push(psh), .push_data(pd), .pop(pp), .pop_data(pdat),
    .dma_req(req), .level(lvl), .underrun(unr), .overflow(ovf));

  logic rclr = 0, ren = 0, rmode = 1, rtwe = 0, rpsh = 0, rpp = 0;
  logic [9:0] rtwd = '0;
  logic [31:0] rpd = '0, rpdat;
  logic rreq, runr, rovf;
  logic [10:0] rlvl;

  audio_thr_fifo #(.RX_MODE(1'b1)) uut_rx (.clk(clk), .rst_n(rst_n), .clr(rclr), .enable(ren),
    .thr_mode(rmode), .thr_we(rtwe), .thr_wdata(rtwd), .push(rpsh), .push_data(rpd), .pop(rpp),
    .pop_data(rpdat), .dma_req(rreq), .level(rlvl), .underrun(runr), .overflow(rovf));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_push(input logic [31:0] d);
    psh = 1; pd = d;
    if (q.size() < 1024) q.push_back(d);
    @(negedge clk);
    psh = 0;
  endtask

  int order_bad = 0;
  task automatic do_pop();
    logic [31:0] exp;
    pp = 1; #1;
    exp = (q.size() == 0) ? 32'h0 : q.pop_front();
    if (pdat !== exp) order_bad++;
    @(negedge clk);
    pp = 0;
  endtask

  task automatic wr_thr(input logic [9:0] v);
    twe = 1; twd = v;
    @(negedge clk);
    twe = 0;
  endtask

  task automatic t_reset();
    chk(lvl == 0, "R1 level", lvl, 0);
    chk(!unr && !ovf, "R1 flags", {unr, ovf}, 0);
    chk(!req, "R1/R12 req idle", req, 0);
  endtask

  task automatic t_underrun();
    pp = 1; #1;
    chk(pdat == 0, "R4 empty data", pdat, 0);
    @(negedge clk); pp = 0;
    chk(unr == 1, "R4 underrun flag", unr, 1);
    chk(lvl == 0, "R4 level", lvl, 0);
    clr = 1; @(negedge clk); clr = 0;
    chk(unr == 0, "R11 flag cleared", unr, 0);
  endtask

  task automatic t_fill();
    wr_thr(10'd3);
    en = 1; mode = 1; #1;
    chk(req == 1, "R6 req at empty", req, 1);
    for (int i = 0; i < 1023; i++) do_push(i * 3 + 7);
    chk(req == 1, "R6 req held one slot free", req, 1);
    do_push(32'h5555_0000);
    chk(lvl == 1024, "R3 full level", lvl, 1024);
    chk(req == 0, "R6 req drops at full", req, 0);
    do_push(32'hDEAD_BEEF);
    chk(ovf == 1, "R3 overflow flag", ovf, 1);
    chk(lvl == 1024, "R3 drop keeps level", lvl, 1024);
    do_push(32'h1);
    chk(ovf == 1, "R3 overflow sticky", ovf, 1);
  endtask

  task automatic t_thresh();
    for (int i = 0; i < 3; i++) do_pop();
    chk(req == 0, "R7 free 3 below 4", req, 0);
    do_pop();
    chk(req == 1, "R7/R5 free 4 meets N+1", req, 1);
    do_push(32'h1234_5678);
    chk(req == 0, "R7 free 3 after push", req, 0);
    do_pop();
    chk(req == 1, "R7 free 4 again", req, 1);
    wr_thr(10'd5);
    chk(req == 0, "R10 new threshold used", req, 0);
    wr_thr(10'd1000);
    while (lvl > 257) do_pop();
    chk(req == 0, "R5 clamp free 767", req, 0);
    do_pop();
    chk(req == 1, "R5 clamp free 768", req, 1);
    chk(order_bad == 0, "R2 pop order", order_bad, 0);
  endtask

  task automatic t_element();
    mode = 0; #1;
    chk(req == 1, "R8 element free", req, 1);
    while (lvl < 1024) do_push(32'hA000_0000 + lvl);
    chk(req == 0, "R8 element full", req, 0);
    do_pop();
    chk(req == 1, "R8 element one free", req, 1);
    chk(order_bad == 0, "R2 order after wrap", order_bad, 0);
  endtask

  task automatic t_disable_clear();
    en = 0; #1;
    chk(req == 0, "R12 disabled", req, 0);
    do_pop();
    chk(lvl == 1022, "R12 pop while disabled", lvl, 1022);
    en = 1; mode = 1;
    clr = 1; @(negedge clk); clr = 0;
    q.delete();
    chk(lvl == 0 && !ovf && !unr, "R11 clear", {lvl, ovf, unr}, 0);
    for (int i = 0; i < 300; i++) do_push(32'hC000_0000 + i);
    chk(req == 1, "R11/R6 fill re-armed", req, 1);
    for (int i = 0; i < 3; i++) do_pop();
    chk(order_bad == 0, "R2 order after clear", order_bad, 0);
  endtask

  task automatic t_rx();
    rtwe = 1; rtwd = 10'd2; @(negedge clk); rtwe = 0;
    ren = 1; rmode = 1;
    rpsh = 1; rpd = 32'h11; @(negedge clk); @(negedge clk); rpsh = 0;
    chk(rreq == 0, "R9 level 2 below 3", rreq, 0);
    rpsh = 1; @(negedge clk); rpsh = 0;
    chk(rreq == 1, "R9 level 3 meets N+1", rreq, 1);
    rpp = 1; @(negedge clk); rpp = 0;
    chk(rreq == 0, "R9 drops below", rreq, 0);
    rmode = 0; #1;
    chk(rreq == 1, "R8 rx element", rreq, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_underrun();
    t_fill();
    t_thresh();
    t_element();
    t_disable_clear();
    t_rx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule